// File: doc/BRIEF.md
# UART Receive Auto-Baud, Wake and Loopback Controller

This block sits in front of a UART receive deserializer. It conditions the receive line and handles three control functions. The first is a one-shot baud-rate measurement, which times a 0x55 sync character and produces a divisor. The second is a start-bit wake detector that raises an interrupt on a falling edge of the line. The third is an internal loopback that feeds the local transmit bit back in as the receive stream. The block passes on one selected receive bit stream, and the deserializer downstream of it samples that stream.

Software writes a mode word through a single write strobe. The word carries these fields: enable, wake arm, loopback, auto-baud arm, 4x oversampling select, receive polarity invert and infrared-mode request. The wake-arm and auto-baud-arm bits clear themselves when their event finishes, and both can be read back. A write in the same cycle as a hardware clear takes priority over the clear.

Top module: `uart_abw_ctl`

## Requirements
- R1: After reset, rx_bit is 1, baud_div is 0, and baud_valid, wake_irq, stat_wake, stat_abaud and stat_irda are all 0.
- R2: With 16x oversampling (cfg_fast=0), a measurement sets baud_div to floor(N/128)-1, clamped at 0. N is the number of clocks from the first falling edge of the sync character to the fifth falling edge, which is the edge that starts bit 7 (8 bit times).
- R3: With 4x oversampling (cfg_fast=1), the same measurement sets baud_div to floor(N/32)-1, clamped at 0.
- R4: When a measurement completes, stat_abaud drops to 0 and baud_valid is high for exactly one cycle.
- R5: From the cycle auto-baud is armed until the line next rises after the measurement completes, rx_bit stays 1, so the sync character never reaches the deserializer.
- R6: If the 16-bit measurement counter reaches 0xFFFF, it saturates there. baud_div then becomes 0xFFFF and stat_abaud still clears.
- R7: With the wake bit armed, the first falling edge on the line gives exactly one single-cycle wake_irq. stat_wake stays 1 while the line is low and clears on the following rising edge.
- R8: With loopback set, rx_bit follows tx_loop_in, and rx_pin has no effect on rx_bit.
- R9: cfg_invert inverts rx_pin after synchronization and before edge detection, so with invert set a low pin is idle. Timing and wake behave the same on the inverted line.
- R10: stat_irda equals the stored infrared request only with enable set and 16x mode; with cfg_fast=1 it reads 0.
- R11: With cfg_enable=0, rx_bit is 1, wake_irq and baud_valid stay 0, and line edges neither start a measurement nor trigger a wake.
- R12: rx_pin passes through a two-flop synchronizer, and each edge is seen as a single-cycle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_enable | input | 1 | Module enable |
| cfg_wake | input | 1 | Arm start-bit wake detection |
| cfg_loop | input | 1 | Route tx_loop_in to the receive path |
| cfg_abaud | input | 1 | Arm baud measurement on next character |
| cfg_fast | input | 1 | 1 = 4x oversampling, 0 = 16x |
| cfg_invert | input | 1 | Invert receive polarity |
| cfg_irda | input | 1 | Infrared mode request |
| rx_pin | input | 1 | Raw asynchronous receive line |
| tx_loop_in | input | 1 | Local transmit bit for loopback |
| rx_bit | output | 1 | Selected receive stream to deserializer |
| wake_irq | output | 1 | Wake interrupt pulse |
| baud_div | output | 16 | Measured baud divisor |
| baud_valid | output | 1 | One-cycle pulse when baud_div updates |
| stat_wake | output | 1 | Readback of self-clearing wake bit |
| stat_abaud | output | 1 | Readback of self-clearing auto-baud bit |
| stat_irda | output | 1 | Effective infrared enable |

## Verification
The bench sweeps bit periods in both oversampling modes, including periods short enough that the quotient is zero. A design off by one clock in the edge-to-edge span would produce the wrong divisor exactly where the integer quotient steps. A missing clamp would wrap to 0xFFFF. One very slow sync character pushes the counter into saturation, where a wrapping counter would report a small bogus divisor. The bench watches rx_bit throughout every sync character, to catch a design that lets the low bits through to the deserializer. The wake cases hold the line low before releasing it. A design that cleared the wake bit on the falling edge, or pulsed the interrupt for more than one cycle, would fail these cases. The bench also checks that a disabled block and a block in loopback ignore pin activity.

// File: rtl/uart_abw_pkg.sv
// Package: shared constants and the stored mode word for the receive
// control block. Assumes a 0x55 sync character sent LSB first.
package uart_abw_pkg;
    // 8 bit times spanned by the timed window
    localparam int SPAN_SHIFT     = 3;
    // log2 of oversampling ratio for 16x and 4x modes
    localparam int OS_SLOW_SHIFT  = 4;
    localparam int OS_FAST_SHIFT  = 2;
    // falling edges after the start edge that close the window
    localparam int FALLS_TO_END   = 4;

    typedef struct packed {
        logic en;
        logic loop;
        logic fast;
        logic inv;
        logic irda;
    } mode_t;
endpackage

// File: rtl/abw_line_front.sv
// Line front end: synchronizes the raw pin, applies polarity inversion,
// selects loopback, and produces single-cycle edge pulses.
// Assumes pin is asynchronous; tx is already in the clk domain.
module abw_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic invert,
    input  logic loop,
    input  logic pin,
    input  logic tx,
    output logic line,
    output logic fall,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   norm;

    // Purpose: metastability chain on the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{1'b1}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Purpose: polarity correction then loopback selection.
    always_comb begin
        norm = sync_q[SYNC_STAGES-1] ^ invert;
        line = loop ? tx : norm;
    end

    // Purpose: previous line value for edge detection, idle while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) prev_q <= 1'b1;
        else               prev_q <= line;
    end

    // Purpose: one-cycle edge pulses, suppressed while disabled.
    always_comb begin
        fall = en && prev_q && !line;
        rise = en && !prev_q && line;
    end
endmodule

// File: rtl/abw_baud_meter.sv
// Baud meter: once armed, times the sync character from its start edge
// to the falling edge that starts bit 7 and derives a divisor. Clears
// its own arm bit when done and masks the data path until the line
// returns high. Assumes fall/rise are single-cycle pulses.
module abw_baud_meter
    import uart_abw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fast,
    input  logic             wr,
    input  logic             wr_arm,
    input  logic             fall,
    input  logic             rise,
    output logic             armed,
    output logic             mask,
    output logic [CNT_W-1:0] divisor,
    output logic             valid
);
    localparam int NF_W = $clog2(FALLS_TO_END + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [NF_W-1:0]  NF_LAST = NF_W'(FALLS_TO_END - 1);

    logic             meas_q;
    logic             tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NF_W-1:0]  nf_q;
    logic [CNT_W:0]   elapsed;
    logic [CNT_W:0]   quot;
    logic [CNT_W-1:0] div_next;

    // Purpose: convert the elapsed count to a clamped or saturated divisor.
    always_comb begin
        elapsed = {1'b0, cnt_q} + 1'b1;
        quot    = fast ? (elapsed >> (SPAN_SHIFT + OS_FAST_SHIFT))
                       : (elapsed >> (SPAN_SHIFT + OS_SLOW_SHIFT));
        if (cnt_q == CNT_MAX)  div_next = CNT_MAX;
        else if (quot == '0)   div_next = '0;
        else                   div_next = CNT_W'(quot - 1'b1);
    end

    // Purpose: arm bit, measurement window, edge count and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            meas_q  <= 1'b0;
            tail_q  <= 1'b0;
            cnt_q   <= '0;
            nf_q    <= '0;
            divisor <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (wr) begin
                armed  <= wr_arm;
                meas_q <= 1'b0;
                tail_q <= 1'b0;
            end else if (!en) begin
                meas_q <= 1'b0;
                tail_q <= 1'b0;
            end else begin
                if (rise) tail_q <= 1'b0;
                if (armed && !meas_q) begin
                    if (fall) begin
                        meas_q <= 1'b1;
                        cnt_q  <= '0;
                        nf_q   <= '0;
                    end
                end else if (armed) begin
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    if (fall) begin
                        if (nf_q == NF_LAST) begin
                            divisor <= div_next;
                            valid   <= 1'b1;
                            armed   <= 1'b0;
                            meas_q  <= 1'b0;
                            tail_q  <= 1'b1;
                        end else begin
                            nf_q <= nf_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign mask = armed || tail_q;
endmodule

// File: rtl/abw_wake_det.sv
// Wake detector: once armed, pulses an interrupt on the first falling
// edge and clears its own arm bit on the next rising edge.
// Assumes fall/rise are single-cycle pulses already gated by enable.
module abw_wake_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wr,
    input  logic wr_arm,
    input  logic fall,
    input  logic rise,
    output logic armed,
    output logic irq
);
    logic seen_q;
    logic irq_q;

    // Purpose: arm bit, falling-edge memory and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            seen_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr) begin
                armed  <= wr_arm;
                seen_q <= 1'b0;
            end else if (!en) begin
                seen_q <= 1'b0;
            end else if (armed) begin
                if (fall && !seen_q) begin
                    irq_q  <= 1'b1;
                    seen_q <= 1'b1;
                end else if (rise && seen_q) begin
                    armed  <= 1'b0;
                    seen_q <= 1'b0;
                end
            end
        end
    end

    assign irq = irq_q && en;
endmodule

// File: rtl/uart_abw_ctl.sv
// Top: receive-side control for a UART. Holds the mode word, feeds the
// line front end, the baud meter and the wake detector, and gates the
// receive stream. Assumes cfg_* fields are sampled on cfg_we.
module uart_abw_ctl
    import uart_abw_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_enable,
    input  logic             cfg_wake,
    input  logic             cfg_loop,
    input  logic             cfg_abaud,
    input  logic             cfg_fast,
    input  logic             cfg_invert,
    input  logic             cfg_irda,
    input  logic             rx_pin,
    input  logic             tx_loop_in,
    output logic             rx_bit,
    output logic             wake_irq,
    output logic [CNT_W-1:0] baud_div,
    output logic             baud_valid,
    output logic             stat_wake,
    output logic             stat_abaud,
    output logic             stat_irda
);
    mode_t mode_q;
    logic  en_q;
    logic  fast_q;
    logic  line;
    logic  edge_fall;
    logic  edge_rise;
    logic  meter_mask;
    logic  meter_valid;

    // Purpose: store the non-self-clearing mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= '0;
        else if (cfg_we) mode_q <= '{en: cfg_enable, loop: cfg_loop, fast: cfg_fast,
                                     inv: cfg_invert, irda: cfg_irda};
    end

    assign en_q   = mode_q.en;
    assign fast_q = mode_q.fast;

    abw_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .en(en_q), .invert(mode_q.inv),
        .loop(mode_q.loop), .pin(rx_pin), .tx(tx_loop_in),
        .line(line), .fall(edge_fall), .rise(edge_rise)
    );

    abw_baud_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .en(en_q), .fast(fast_q),
        .wr(cfg_we), .wr_arm(cfg_abaud), .fall(edge_fall), .rise(edge_rise),
        .armed(stat_abaud), .mask(meter_mask), .divisor(baud_div),
        .valid(meter_valid)
    );

    abw_wake_det u_wake (
        .clk(clk), .rst_n(rst_n), .en(en_q), .wr(cfg_we), .wr_arm(cfg_wake),
        .fall(edge_fall), .rise(edge_rise), .armed(stat_wake), .irq(wake_irq)
    );

    // Purpose: output gating of stream, valid pulse and infrared enable.
    always_comb begin
        rx_bit     = (en_q && !meter_mask) ? line : 1'b1;
        baud_valid = meter_valid && en_q;
        stat_irda  = mode_q.irda && en_q && !fast_q;
    end
endmodule

// File: rtl/uart_abw_checker.sv
// Checker: temporal properties of the receive control block, bound to
// the top. Assumes synchronous active-low reset.
module uart_abw_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic en_q,
    input logic fast_q,
    input logic edge_rise,
    input logic rx_bit,
    input logic wake_irq,
    input logic baud_valid,
    input logic stat_wake,
    input logic stat_abaud,
    input logic stat_irda
);
    // R11: disabled block stays idle
    p_idle_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (rx_bit && !wake_irq && !baud_valid));
    // R7: interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);
    // R4: result arrives with the arm bit already cleared
    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        baud_valid |-> !stat_abaud);
    // R4: valid is one cycle wide
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        baud_valid |=> !baud_valid);
    // R5: stream masked while armed
    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_abaud |-> rx_bit);
    // R10: infrared never active in 4x mode
    p_irda_4x_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_q |-> !stat_irda);
    // R7: hardware clear of wake bit only follows a rising edge
    p_wake_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat_wake) && !$past(cfg_we)) |-> $past(edge_rise));
endmodule

bind uart_abw_ctl uart_abw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .en_q(en_q), .fast_q(fast_q),
    .edge_rise(edge_rise), .rx_bit(rx_bit), .wake_irq(wake_irq),
    .baud_valid(baud_valid), .stat_wake(stat_wake), .stat_abaud(stat_abaud),
    .stat_irda(stat_irda)
);

// File: tb/uart_abw_ctl_test.sv
module uart_abw_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_enable = 1'b0, cfg_wake = 1'b0, cfg_loop = 1'b0;
    logic        cfg_abaud = 1'b0, cfg_fast = 1'b0, cfg_invert = 1'b0, cfg_irda = 1'b0;
    logic        rx_pin = 1'b1, tx_loop_in = 1'b1;
    logic        rx_bit, wake_irq, baud_valid, stat_wake, stat_abaud, stat_irda;
    logic [15:0] baud_div;

    int checks = 0, errors = 0;
    int irq_cnt = 0, valid_cnt = 0, low_cnt = 0;
    logic inv_now = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    uart_abw_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .cfg_wake(cfg_wake), .cfg_loop(cfg_loop), .cfg_abaud(cfg_abaud),
        .cfg_fast(cfg_fast), .cfg_invert(cfg_invert), .cfg_irda(cfg_irda),
        .rx_pin(rx_pin), .tx_loop_in(tx_loop_in), .rx_bit(rx_bit),
        .wake_irq(wake_irq), .baud_div(baud_div), .baud_valid(baud_valid),
        .stat_wake(stat_wake), .stat_abaud(stat_abaud), .stat_irda(stat_irda)
    );

    // event monitor sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wake_irq)   irq_cnt++;
            if (baud_valid) valid_cnt++;
            if (!rx_bit)    low_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input bit en, input bit wk, input bit lp, input bit ab,
                       input bit fs, input bit iv, input bit ir);
        @(posedge clk); #1;
        cfg_we = 1; cfg_enable = en; cfg_wake = wk; cfg_loop = lp;
        cfg_abaud = ab; cfg_fast = fs; cfg_invert = iv; cfg_irda = ir;
        inv_now = iv;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    // drive a logical line level, honouring the current polarity
    task automatic drive(input bit lvl, input int cyc);
        rx_pin = lvl ^ inv_now;
        tick(cyc);
    endtask

    task automatic send_sync(input int b);
        drive(1'b0, b);
        for (int k = 0; k < 8; k++) drive(((8'h55 >> k) & 1) != 0, b);
        drive(1'b1, b);
    endtask

    function automatic int exp_div(input int b, input bit fs);
        int q;
        q = (8 * b) >> (fs ? 5 : 7);
        return (q == 0) ? 0 : q - 1;
    endfunction

    task automatic measure(input int b, input bit fs, input bit iv, input int exp, input string tag);
        cfg(1, 0, 0, 1, fs, iv, 0);
        drive(1'b1, 6);
        valid_cnt = 0; low_cnt = 0;
        send_sync(b);
        tick(6);
        check(baud_div == 16'(exp), tag, baud_div, exp);
        check(stat_abaud == 1'b0, "R4 abaud self-clear", stat_abaud, 0);
        check(valid_cnt == 1, "R4 single valid pulse", valid_cnt, 1);
        check(low_cnt == 0, "R5 sync hidden", low_cnt, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        tick(4);
        rst_n = 1; tick(1);
        // R1 reset state
        check(rx_bit == 1 && baud_div == 0 && !baud_valid && !wake_irq,
              "R1 reset outputs", {rx_bit, baud_valid, wake_irq}, 4);
        check(!stat_wake && !stat_abaud && !stat_irda, "R1 reset status",
              {stat_wake, stat_abaud, stat_irda}, 0);

        // R2 16x sweep, including clamp to 0
        for (int b = 8; b <= 160; b += 8) measure(b, 0, 0, exp_div(b, 0), "R2 div16x");
        measure(40, 0, 0, exp_div(40, 0), "R2 div16x odd");
        // R3 4x sweep
        for (int b = 3; b <= 40; b += 3) measure(b, 1, 0, exp_div(b, 1), "R3 div4x");
        // R9 inverted polarity: idle low pin is idle
        cfg(1, 0, 0, 0, 0, 1, 0);
        rx_pin = 0; tick(6);
        check(rx_bit == 1, "R9 inverted idle", rx_bit, 1);
        measure(64, 0, 1, exp_div(64, 0), "R9 div inverted");
        inv_now = 0;

        // R12 edge seen after synchronizer only
        cfg(1, 0, 0, 0, 0, 0, 0);
        drive(1'b1, 4);
        rx_pin = 0; tick(1);
        check(rx_bit == 1, "R12 sync delay 1", rx_bit, 1);
        tick(1);
        check(rx_bit == 0, "R12 sync delay 2", rx_bit, 0);
        drive(1'b1, 4);

        // R7 wake: one pulse, flag held while low, cleared by rise
        cfg(1, 1, 0, 0, 0, 0, 0);
        irq_cnt = 0;
        drive(1'b0, 20);
        check(irq_cnt == 1, "R7 one irq", irq_cnt, 1);
        check(stat_wake == 1, "R7 flag held low", stat_wake, 1);
        drive(1'b1, 5);
        check(stat_wake == 0, "R7 cleared on rise", stat_wake, 0);
        drive(1'b0, 5); drive(1'b1, 5);
        check(irq_cnt == 1, "R7 no irq once cleared", irq_cnt, 1);

        // R11 disabled: no wake, no measurement, rx idle
        cfg(0, 1, 0, 1, 0, 0, 0);
        irq_cnt = 0; valid_cnt = 0; low_cnt = 0;
        send_sync(16);
        drive(1'b0, 8); drive(1'b1, 8);
        check(irq_cnt == 0 && valid_cnt == 0 && low_cnt == 0, "R11 idle when off",
              irq_cnt + valid_cnt + low_cnt, 0);
        check(stat_wake == 1 && stat_abaud == 1, "R11 no detection",
              {stat_wake, stat_abaud}, 3);

        // R8 loopback follows tx, ignores pin
        cfg(1, 0, 1, 0, 0, 0, 0);
        tx_loop_in = 0; rx_pin = 1; tick(3);
        check(rx_bit == 0, "R8 loop low", rx_bit, 0);
        tx_loop_in = 1; rx_pin = 0; tick(3);
        check(rx_bit == 1, "R8 pin ignored", rx_bit, 1);
        rx_pin = 1; tick(3);

        // R10 infrared request
        cfg(1, 0, 0, 0, 1, 0, 1); tick(1);
        check(stat_irda == 0, "R10 ignored in 4x", stat_irda, 0);
        cfg(1, 0, 0, 0, 0, 0, 1); tick(1);
        check(stat_irda == 1, "R10 allowed in 16x", stat_irda, 1);

        // R6 counter saturation
        measure(8200, 0, 0, 16'hFFFF, "R6 saturate");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule